// File: doc/BRIEF.md
# Two-Phase Command Register Decoder

This block is a 16-bit slave on a synchronous host bus. Each register access is split into a command phase and an optional data phase, and an address-select input decides which phase a bus cycle belongs to. In the command phase, the host writes a word whose low byte is a command code. The code names a register and a direction, and it also fixes how many data words follow. In the data phase, the host then moves exactly that many words into or out of the chosen register.

The register set holds the following:
- sixteen endpoint configuration words: two for the control pipe and fourteen for numbered endpoints;
- a device address word;
- a mode word;
- a hardware configuration word;
- a DMA configuration word;
- a DMA counter word;
- a 32-bit interrupt enable register, moved as two words.

Paired codes give write and read access to the same register. The block keeps count of how many data words are still expected. It returns read data in the same cycle as the read strobe.

Top module: `hbus_cmd_regs`

## Requirements
- R1: After reset every register reads as zero, `data_pend` is low, and `rdata` is zero.
- R2: A write strobe with `a_cmd`=1 is a command. Only `wdata[7:0]` forms the code, and `wdata[15:8]` has no effect on decoding.
- R3: Codes 0x20..0x2F each write one word to endpoint configuration slot (code-0x20). Codes 0x30..0x3F each read one word from slot (code-0x30). Slot 0 is the control OUT pipe, slot 1 is the control IN pipe, and slot n+1 is numbered endpoint n.
- R4: Even codes write one word and the next odd code reads that word back. The pairs are: device address 0xB6/0xB7, mode 0xB8/0xB9, hardware configuration 0xBA/0xBB, DMA configuration 0xF0/0xF1, and DMA counter 0xF2/0xF3.
- R5: Code 0xC2 writes the 32-bit interrupt enable register and code 0xC3 reads it. Each takes two data words, with the least significant word first.
- R6: After the expected number of data words, the data phase ends. Further data writes change nothing, and further data reads return zero.
- R7: A code not listed in R3 to R5 is ignored. It also cancels any pending data phase, so `data_pend` goes low.
- R8: A new command always discards an unfinished data phase and restarts at word 0 of the new command.
- R9: `rdata` shows the current word of a pending read command in the same cycle as `rd_en`. At all other times `rdata` is zero. A data write strobe during a read command is ignored and does not consume a word.
- R10: `data_pend` is high from the cycle after a recognised command until the cycle after its last data word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_cmd | input | 1 | Phase select: 1 = command word, 0 = data word |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| wdata | input | 16 | Write data or command word |
| rdata | output | 16 | Read data, valid while `rd_en` is high |
| data_pend | output | 1 | Data words remain for the current command |

## Verification
A wrong word index or word count shows up at the ports as an early or late fall of `data_pend`. It also shows up as interrupt-enable halves that come back swapped or in the wrong place, visible on the very next read-back. A bad target decode shows up as a write that lands in the wrong slot. The directed read-back of every slot after all slots have been written catches this, within one pass over the map. A stale pending phase after an unknown code or an aborting command shows up as a stray write that corrupts a register, or as a nonzero `rdata` on the next data strobe.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  localparam int DATA_W    = 16;
  localparam int EP_IDX_W  = 4;
  localparam int N_EP      = 16;
  localparam int CNT_W     = 2;
  localparam int IRQ_WORDS = 2;
  localparam int N_MISC    = 5;

  localparam logic [7:0] CODE_ADDR   = 8'hB6;
  localparam logic [7:0] CODE_MODE   = 8'hB8;
  localparam logic [7:0] CODE_HWCFG  = 8'hBA;
  localparam logic [7:0] CODE_IRQEN  = 8'hC2;
  localparam logic [7:0] CODE_DMACFG = 8'hF0;
  localparam logic [7:0] CODE_DMACNT = 8'hF2;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_EPCFG, TGT_ADDR, TGT_MODE,
    TGT_HWCFG, TGT_IRQEN, TGT_DMACFG, TGT_DMACNT
  } tgt_e;

  typedef struct packed {
    logic                valid;
    tgt_e                tgt;
    logic                rd;
    logic [EP_IDX_W-1:0] ep_idx;
    logic [CNT_W-1:0]    nwords;
  } cmd_t;
endpackage

// File: rtl/hbd_rst_sync.sv
module hbd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/hbd_cmd_decode.sv
module hbd_cmd_decode
  import hbd_pkg::*;
(
  input  logic [7:0] code,
  output cmd_t       dec
);
  always_comb begin
    dec        = '0;
    dec.tgt    = TGT_NONE;
    if (code[7:5] == 3'b001) begin
      dec.valid  = 1'b1;
      dec.tgt    = TGT_EPCFG;
      dec.rd     = code[4];
      dec.ep_idx = code[EP_IDX_W-1:0];
      dec.nwords = CNT_W'(1);
    end else begin
      dec.valid  = 1'b1;
      dec.rd     = code[0];
      dec.nwords = CNT_W'(1);
      case (code[7:1])
        CODE_ADDR[7:1]:   dec.tgt = TGT_ADDR;
        CODE_MODE[7:1]:   dec.tgt = TGT_MODE;
        CODE_HWCFG[7:1]:  dec.tgt = TGT_HWCFG;
        CODE_DMACFG[7:1]: dec.tgt = TGT_DMACFG;
        CODE_DMACNT[7:1]: dec.tgt = TGT_DMACNT;
        CODE_IRQEN[7:1]: begin
          dec.tgt    = TGT_IRQEN;
          dec.nwords = CNT_W'(IRQ_WORDS);
        end
        default: begin
          dec.valid  = 1'b0;
          dec.rd     = 1'b0;
          dec.nwords = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/hbd_phase_ctrl.sv
module hbd_phase_ctrl
  import hbd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_stb,
  input  cmd_t             dec_in,
  input  logic             data_wr,
  input  logic             data_rd,
  output cmd_t             cur_q,
  output logic             pend_q,
  output logic [CNT_W-1:0] idx_q,
  output logic             word_wr,
  output logic             word_rd
);
  cmd_t             cur_n;
  logic             pend_n;
  logic [CNT_W-1:0] idx_n;
  logic [CNT_W-1:0] idx_inc;
  logic             adv;
  logic             last;
  logic             ld;

  always_comb begin
    word_wr = data_wr & pend_q & ~cur_q.rd;
    word_rd = data_rd & pend_q &  cur_q.rd;
    adv     = word_wr | word_rd;
    idx_inc = idx_q + 1'b1;
    last    = (idx_inc == cur_q.nwords);
    ld      = cmd_stb | adv;
    cur_n   = cur_q;
    pend_n  = pend_q;
    idx_n   = idx_q;
    if (cmd_stb) begin
      cur_n  = dec_in;
      pend_n = dec_in.valid;
      idx_n  = '0;
    end else if (adv) begin
      pend_n = ~last;
      idx_n  = last ? '0 : idx_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      pend_q <= 1'b0;
      idx_q  <= '0;
    end else if (ld) begin
      cur_q  <= cur_n;
      pend_q <= pend_n;
      idx_q  <= idx_n;
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (idx_q < cur_q.nwords)); // R5
  AST_LAST_WORD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last && !cmd_stb) |=> !pend_q); // R6
  AST_UNKNOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !dec_in.valid) |=> !pend_q); // R7
  AST_CMD_ZERO_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> (idx_q == '0)); // R8
endmodule

// File: rtl/hbd_regbank.sv
module hbd_regbank
  import hbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  cmd_t              sel,
  input  logic [CNT_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word
);
  logic [N_EP-1:0][DATA_W-1:0]      ep_q;
  logic [IRQ_WORDS-1:0][DATA_W-1:0] irq_q;
  logic [N_MISC-1:0][DATA_W-1:0]    misc_q;
  logic [N_EP-1:0]                  ep_we;
  logic [IRQ_WORDS-1:0]             irq_we;
  logic [N_MISC-1:0]                misc_we;
  logic [N_MISC-1:0]                misc_hit;

  always_comb begin
    misc_hit = '0;
    case (sel.tgt)
      TGT_ADDR:   misc_hit[0] = 1'b1;
      TGT_MODE:   misc_hit[1] = 1'b1;
      TGT_HWCFG:  misc_hit[2] = 1'b1;
      TGT_DMACFG: misc_hit[3] = 1'b1;
      TGT_DMACNT: misc_hit[4] = 1'b1;
      default:    misc_hit    = '0;
    endcase
  end

  for (genvar g = 0; g < N_EP; g++) begin : g_ep
    assign ep_we[g] = we && (sel.tgt == TGT_EPCFG) && (sel.ep_idx == EP_IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ep_q[g] <= '0;
      else if (ep_we[g]) ep_q[g] <= wdata;
    end
  end

  for (genvar g = 0; g < IRQ_WORDS; g++) begin : g_irq
    assign irq_we[g] = we && (sel.tgt == TGT_IRQEN) && (idx == CNT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq_q[g] <= '0;
      else if (irq_we[g]) irq_q[g] <= wdata;
    end
  end

  for (genvar g = 0; g < N_MISC; g++) begin : g_misc
    assign misc_we[g] = we && misc_hit[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          misc_q[g] <= '0;
      else if (misc_we[g]) misc_q[g] <= wdata;
    end
  end

  always_comb begin
    rd_word = '0;
    case (sel.tgt)
      TGT_EPCFG: begin
        for (int i = 0; i < N_EP; i++)
          if (sel.ep_idx == EP_IDX_W'(i)) rd_word = ep_q[i];
      end
      TGT_IRQEN: begin
        for (int i = 0; i < IRQ_WORDS; i++)
          if (idx == CNT_W'(i)) rd_word = irq_q[i];
      end
      default: begin
        for (int i = 0; i < N_MISC; i++)
          if (misc_hit[i]) rd_word = misc_q[i];
      end
    endcase
  end

  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(ep_q) && $stable(irq_q) && $stable(misc_q))); // R6
endmodule

// File: rtl/hbus_cmd_regs.sv
module hbus_cmd_regs
  import hbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_cmd,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              data_pend
);
  logic              rst_sync_n;
  logic              cmd_stb;
  logic              data_wr;
  logic              data_rd;
  cmd_t              dec;
  cmd_t              cur;
  logic              pend;
  logic [CNT_W-1:0]  idx;
  logic              word_wr;
  logic              word_rd;
  logic [DATA_W-1:0] rd_word;

  assign cmd_stb = wr_en &  a_cmd;
  assign data_wr = wr_en & ~a_cmd;
  assign data_rd = rd_en & ~a_cmd;

  hbd_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hbd_cmd_decode i_decode (
    .code (wdata[7:0]),
    .dec  (dec)
  );

  hbd_phase_ctrl i_phase (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cmd_stb (cmd_stb),
    .dec_in  (dec),
    .data_wr (data_wr),
    .data_rd (data_rd),
    .cur_q   (cur),
    .pend_q  (pend),
    .idx_q   (idx),
    .word_wr (word_wr),
    .word_rd (word_rd)
  );

  hbd_regbank i_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (word_wr),
    .sel     (cur),
    .idx     (idx),
    .wdata   (wdata),
    .rd_word (rd_word)
  );

  assign rdata     = word_rd ? rd_word : '0;
  assign data_pend = pend;

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(rd_en && !a_cmd) |-> (rdata == '0)); // R9
  AST_NOPEND_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !data_pend |-> (rdata == '0)); // R6
endmodule

// File: tb/test_hbus_cmd_regs.sv
module test_hbus_cmd_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_cmd = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        data_pend;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  hbus_cmd_regs i_hbus_cmd_regs (
    .clk(clk), .rst_n(rst_n), .a_cmd(a_cmd), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .data_pend(data_pend)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_cmd(input logic [15:0] w);
    @(negedge clk); a_cmd = 1'b1; wr_en = 1'b1; rd_en = 1'b0; wdata = w;
    @(posedge clk); #1 wr_en = 1'b0; a_cmd = 1'b0; wdata = '0;
  endtask

  task automatic bus_wr(input logic [15:0] w);
    @(negedge clk); a_cmd = 1'b0; wr_en = 1'b1; rd_en = 1'b0; wdata = w;
    @(posedge clk); #1 wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(output logic [15:0] r);
    @(negedge clk); a_cmd = 1'b0; rd_en = 1'b1; wr_en = 1'b0;
    #1 r = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] r;
    chk("R1 pend", {15'd0, data_pend}, 16'd0);
    chk("R1 rdata idle", rdata, 16'h0000);
    bus_cmd(16'h00B9); bus_rd(r); chk("R1 mode", r, 16'h0000);
    bus_cmd(16'h00C3); bus_rd(r); chk("R1 irq lo", r, 16'h0000);
    bus_rd(r); chk("R1 irq hi", r, 16'h0000);
  endtask

  task automatic t_epcfg();
    logic [15:0] r;
    for (int i = 0; i < 16; i++) begin
      bus_cmd(16'h0020 + 16'(i)); bus_wr(16'h5A00 + 16'(i * 3));
    end
    for (int i = 0; i < 16; i++) begin
      bus_cmd(16'h0030 + 16'(i)); bus_rd(r);
      chk("R3 epcfg slot", r, 16'h5A00 + 16'(i * 3));
    end
  endtask

  task automatic t_single();
    logic [15:0] r;
    logic [7:0]  codes [5] = '{8'hB6, 8'hB8, 8'hBA, 8'hF0, 8'hF2};
    for (int i = 0; i < 5; i++) begin
      bus_cmd({8'h00, codes[i]});
      #1 chk("R10 pend after cmd", {15'd0, data_pend}, 16'd1);
      bus_wr(16'hC100 + 16'(i));
      #1 chk("R10 pend after word", {15'd0, data_pend}, 16'd0);
    end
    for (int i = 0; i < 5; i++) begin
      bus_cmd({8'h00, codes[i] | 8'h01}); bus_rd(r);
      chk("R4 one-word readback", r, 16'hC100 + 16'(i));
    end
  endtask

  task automatic t_irq();
    logic [15:0] r;
    bus_cmd(16'h00C2); bus_wr(16'h1234);
    #1 chk("R5 pend mid", {15'd0, data_pend}, 16'd1);
    bus_wr(16'hABCD);
    #1 chk("R5 pend end", {15'd0, data_pend}, 16'd0);
    bus_cmd(16'h00C3); bus_rd(r); chk("R5 lsw first", r, 16'h1234);
    bus_rd(r); chk("R5 msw second", r, 16'hABCD);
  endtask

  task automatic t_overrun();
    logic [15:0] r;
    bus_cmd(16'h00B6); bus_wr(16'h0042); bus_wr(16'hFFFF);
    bus_cmd(16'h00B7); bus_rd(r); chk("R6 extra write ignored", r, 16'h0042);
    bus_rd(r); chk("R6 extra read zero", r, 16'h0000);
  endtask

  task automatic t_unknown();
    logic [15:0] r;
    bus_cmd(16'h00C2);
    bus_cmd(16'h0055);
    #1 chk("R7 pend cleared", {15'd0, data_pend}, 16'd0);
    bus_wr(16'h9999);
    bus_cmd(16'h0010); bus_wr(16'h8888);
    bus_cmd(16'h00C3); bus_rd(r); chk("R7 irq lo kept", r, 16'h1234);
    bus_rd(r); chk("R7 irq hi kept", r, 16'hABCD);
  endtask

  task automatic t_abort();
    logic [15:0] r;
    bus_cmd(16'h00C2); bus_wr(16'h1111);
    bus_cmd(16'h00C2); bus_wr(16'h2222); bus_wr(16'h3333);
    bus_cmd(16'h00C3); bus_rd(r);
    bus_cmd(16'h00C3); bus_rd(r); chk("R8 restart word0", r, 16'h2222);
    bus_rd(r); chk("R8 word1", r, 16'h3333);
  endtask

  task automatic t_upper();
    logic [15:0] r;
    bus_cmd(16'hFFB8); bus_wr(16'h0077);
    bus_cmd(16'h12B9); bus_rd(r); chk("R2 upper byte ignored", r, 16'h0077);
    bus_wr(16'h00B8); bus_wr(16'h0001);
    bus_cmd(16'h00B9); bus_rd(r); chk("R2 data word not a command", r, 16'h0077);
  endtask

  task automatic t_dir();
    logic [15:0] r;
    bus_cmd(16'h00B9); bus_wr(16'hDEAD);
    #1 chk("R9 pend kept", {15'd0, data_pend}, 16'd1);
    chk("R9 idle rdata", rdata, 16'h0000);
    bus_rd(r); chk("R9 read value", r, 16'h0077);
    bus_cmd(16'h00B9);
    @(negedge clk); a_cmd = 1'b1; rd_en = 1'b1;
    #1 chk("R9 rdata zero in cmd phase", rdata, 16'h0000);
    @(posedge clk); #1 rd_en = 1'b0; a_cmd = 1'b0;
    bus_rd(r); chk("R9 mode unchanged", r, 16'h0077);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_epcfg();
    t_single();
    t_irq();
    t_overrun();
    t_unknown();
    t_abort();
    t_upper();
    t_dir();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog: actual=timeout expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule